// File: doc/BRIEF.md
# System Interrupt Router and Masker

This block collects thirty-two system interrupt lines and keeps a master pending word with one bit per line. Each line is tied to a fixed processor priority level by a built-in table; a line whose level is zero is dead and leaves no trace. A disable word gates delivery, line by line and globally through its top bit. A programmable target index names the one processor that receives every routed event.

On every clock the lines are compared with their previous sample. A rising edge sets the pending bit, and a falling edge clears it. Each edge is also sent to the target processor's level word as a one-cycle set or clear mask. When an edge qualifies, a one-cycle request leaves the block. It carries the level, the target index and an interrupt code: a fixed external-interrupt type in the high nibble and the level in the low nibble. Software reaches the pending, disable and target state through a small word-indexed register window, with separate offsets for enabling and disabling.

Top module: `sys_irq_router`

## Requirements
- R1: After reset, offset 0 (pending) reads 0, offset 1 (disable) reads 0xFFFFFFFF, offset 4 (target) reads 0, and no request or level update is issued.
- R2: The read data depends on the 3-bit word offset: 0 gives pending, 1 gives disable and 4 gives the target in bits 3:0. Offsets 2, 3, 5, 6 and 7 read 0.
- R3: A write to offset 2 clears every disable bit that is set in the written value OR 0x7FB2007F, so the positions in 0x7FB2007F always end up clear.
- R4: A write to offset 3 sets the disable bits written in (value AND NOT 0x7FB2007F), and in the same cycle clears those pending bits. The positions in 0x7FB2007F are never set.
- R5: A write to offset 4 stores bits 3:0 of the written value as the target index.
- R6: A rising edge on line i with a non-zero level sets pending bit i, and a falling edge clears it. The levels for lines 0 to 31, in order, are 2,3,5,7,9,11,0,14,3,5,7,9,11,13,12,12,6,0,4,10,8,0,11,0,0,0,0,0,15,0,0,0. Lines at level 0 never set pending, never produce a level update and never produce a request.
- R7: In the cycle after any edge on a mapped line, lvl_vld_o pulses with lvl_cpu_o equal to the target. Bit L of lvl_set_o marks a rise at level L, and bit L of lvl_clr_o marks a fall. When several lines sharing a level change together, the highest-numbered line decides.
- R8: A rising edge requests only if the line's disable bit is clear and disable bit 31 is clear, and either the level is 15 or cpu_ie_i is 1 with the level above cpu_thresh_i.
- R9: A level-15 line requests regardless of cpu_thresh_i and cpu_ie_i.
- R10: When several qualifying lines rise in one cycle, the request level is that of the highest-numbered one.
- R11: A request has irq_cpu_o equal to the target and irq_code_o equal to {EXT_TYPE, level}, with EXT_TYPE defaulting to 4'h1.
- R12: irq_req_o is high for exactly one cycle for each sampled group of rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Interrupt source lines, level sensitive |
| cpu_thresh_i | input | 4 | Target processor's current priority threshold |
| cpu_ie_i | input | 1 | Target processor's interrupt enable |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on reg_addr_i |
| irq_req_o | output | 1 | One-cycle interrupt request |
| irq_lvl_o | output | 4 | Requested level |
| irq_cpu_o | output | 4 | Processor the request is sent to |
| irq_code_o | output | 8 | Interrupt type and level |
| lvl_vld_o | output | 1 | Level-word update strobe |
| lvl_cpu_o | output | 4 | Processor whose level word is updated |
| lvl_set_o | output | 16 | Level bits to set |
| lvl_clr_o | output | 16 | Level bits to clear |

## Verification
The hardest case to reach is a single cycle in which lines that share a level move in opposite directions while other lines rise. Here the set/clear outcome and the request level depend on the ascending-order rule and not on edge detection alone. The stimulus reaches it in steps. It first programs a mixed disable pattern: a masking write leaves a forced-enable hole, and a partial enable write drops the global bit while keeping other lines masked. It then swaps lines 1 and 8, both at level 3, in both directions, with higher lines held steady. A reference model predicts every request and level update into scoreboard queues, and a monitor drains them as the pulses appear.

// File: rtl/sys_irq_router_pkg.sv
package sys_irq_router_pkg;

  localparam int unsigned NSRC       = 32;
  localparam int unsigned LVL_W      = 4;
  localparam int unsigned NLVL       = 1 << LVL_W;
  localparam int unsigned CPU_W      = 4;
  localparam int unsigned OFS_W      = 3;
  localparam int unsigned GLOBAL_BIT = NSRC - 1;
  localparam logic [NSRC-1:0] FORCED = 32'h7FB2007F;
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(NLVL - 1);

  typedef enum logic [OFS_W-1:0] {
    OFS_PEND = 3'd0,
    OFS_DIS  = 3'd1,
    OFS_ENA  = 3'd2,
    OFS_MSK  = 3'd3,
    OFS_TGT  = 3'd4
  } ofs_e;

  // Fixed priority level of each source line; 0 marks an unconnected line.
  function automatic logic [LVL_W-1:0] level_of(input int unsigned idx);
    logic [LVL_W-1:0] r;
    case (idx)
      0:  r = 4'd2;
      1:  r = 4'd3;
      2:  r = 4'd5;
      3:  r = 4'd7;
      4:  r = 4'd9;
      5:  r = 4'd11;
      7:  r = 4'd14;
      8:  r = 4'd3;
      9:  r = 4'd5;
      10: r = 4'd7;
      11: r = 4'd9;
      12: r = 4'd11;
      13: r = 4'd13;
      14: r = 4'd12;
      15: r = 4'd12;
      16: r = 4'd6;
      18: r = 4'd4;
      19: r = 4'd10;
      20: r = 4'd8;
      22: r = 4'd11;
      28: r = 4'd15;
      default: r = 4'd0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sirq_event_fold.sv
module sirq_event_fold
  import sys_irq_router_pkg::*;
(
  input  logic [NSRC-1:0]  src_now,
  input  logic [NSRC-1:0]  src_prev,
  input  logic [NSRC-1:0]  dis_cur,
  input  logic [LVL_W-1:0] thresh,
  input  logic             ie,
  output logic [NSRC-1:0]  pend_set,
  output logic [NSRC-1:0]  pend_clr,
  output logic [NLVL-1:0]  lvl_set,
  output logic [NLVL-1:0]  lvl_clr,
  output logic             any_chg,
  output logic             hit,
  output logic [LVL_W-1:0] hit_lvl
);

  logic [NSRC-1:0] mapped;
  logic [NSRC-1:0] rise;
  logic [NSRC-1:0] fall;
  logic [NSRC-1:0] qual;

  // Per-line decode: mapping, edges and delivery qualification.
  for (genvar g = 0; g < NSRC; g++) begin : g_line
    localparam logic [LVL_W-1:0] LV = level_of(g);
    assign mapped[g] = (LV != '0);
    assign rise[g]   = mapped[g] &  src_now[g] & ~src_prev[g];
    assign fall[g]   = mapped[g] & ~src_now[g] &  src_prev[g];
    assign qual[g]   = ~dis_cur[g] & ~dis_cur[GLOBAL_BIT] &
                       ((LV == TOP_LVL) | (ie & (LV > thresh)));
  end

  assign pend_set = rise;
  assign pend_clr = fall;
  assign any_chg  = |(rise | fall);

  // Ascending walk: a later line overrides an earlier one at the same level,
  // and the last qualifying riser names the request level.
  always_comb begin
    lvl_set = '0;
    lvl_clr = '0;
    hit     = 1'b0;
    hit_lvl = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (rise[i]) begin
        lvl_set[level_of(i)] = 1'b1;
        lvl_clr[level_of(i)] = 1'b0;
        if (qual[i]) begin
          hit     = 1'b1;
          hit_lvl = level_of(i);
        end
      end else if (fall[i]) begin
        lvl_clr[level_of(i)] = 1'b1;
        lvl_set[level_of(i)] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/sirq_state_regs.sv
module sirq_state_regs
  import sys_irq_router_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [OFS_W-1:0] addr,
  input  logic [NSRC-1:0]  wdata,
  input  logic [NSRC-1:0]  pend_set,
  input  logic [NSRC-1:0]  pend_clr,
  output logic [NSRC-1:0]  pend_q,
  output logic [NSRC-1:0]  dis_q,
  output logic [CPU_W-1:0] tgt_q,
  output logic [NSRC-1:0]  rdata
);

  logic             wr_ena, wr_msk, wr_tgt;
  logic [NSRC-1:0]  msk_bits;
  logic [NSRC-1:0]  pend_d, dis_d;
  logic [CPU_W-1:0] tgt_d;
  logic             pend_en, dis_en, tgt_en;

  assign wr_ena   = wr & (ofs_e'(addr) == OFS_ENA);
  assign wr_msk   = wr & (ofs_e'(addr) == OFS_MSK);
  assign wr_tgt   = wr & (ofs_e'(addr) == OFS_TGT);
  assign msk_bits = wdata & ~FORCED;

  // Next state: source edges first, a masking write applied on top.
  always_comb begin
    pend_d = (pend_q | pend_set) & ~pend_clr;
    if (wr_msk) pend_d = pend_d & ~msk_bits;
    dis_d = dis_q;
    if (wr_ena) dis_d = dis_q & ~(wdata | FORCED);
    if (wr_msk) dis_d = dis_q | msk_bits;
    tgt_d = wdata[CPU_W-1:0];
  end

  assign pend_en = (|pend_set) | (|pend_clr) | wr_msk;
  assign dis_en  = wr_ena | wr_msk;
  assign tgt_en  = wr_tgt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      dis_q  <= '1;
      tgt_q  <= '0;
    end else begin
      if (pend_en) pend_q <= pend_d;
      if (dis_en)  dis_q  <= dis_d;
      if (tgt_en)  tgt_q  <= tgt_d;
    end
  end

  always_comb begin
    case (ofs_e'(addr))
      OFS_PEND: rdata = pend_q;
      OFS_DIS:  rdata = dis_q;
      OFS_TGT:  rdata = {{(NSRC-CPU_W){1'b0}}, tgt_q};
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/sirq_req_reg.sv
module sirq_req_reg
  import sys_irq_router_pkg::*;
#(
  parameter logic [3:0] EXT_TYPE = 4'h1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic [LVL_W-1:0] hit_lvl,
  input  logic [CPU_W-1:0] tgt,
  input  logic             any_chg,
  input  logic [NLVL-1:0]  lvl_set,
  input  logic [NLVL-1:0]  lvl_clr,
  output logic             irq_req,
  output logic [LVL_W-1:0] irq_lvl,
  output logic [CPU_W-1:0] irq_cpu,
  output logic [7:0]       irq_code,
  output logic             upd_vld,
  output logic [CPU_W-1:0] upd_cpu,
  output logic [NLVL-1:0]  upd_set,
  output logic [NLVL-1:0]  upd_clr
);

  logic             req_d;
  logic [LVL_W-1:0] lvl_d;
  logic [CPU_W-1:0] cpu_d;
  logic             vld_d;
  logic [NLVL-1:0]  set_d, clr_d;

  always_comb begin
    req_d = hit;
    lvl_d = hit ? hit_lvl : '0;
    cpu_d = tgt;
    vld_d = any_chg;
    set_d = any_chg ? lvl_set : '0;
    clr_d = any_chg ? lvl_clr : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req <= 1'b0;
      irq_lvl <= '0;
      irq_cpu <= '0;
      upd_vld <= 1'b0;
      upd_cpu <= '0;
      upd_set <= '0;
      upd_clr <= '0;
    end else begin
      irq_req <= req_d;
      irq_lvl <= lvl_d;
      irq_cpu <= cpu_d;
      upd_vld <= vld_d;
      upd_cpu <= cpu_d;
      upd_set <= set_d;
      upd_clr <= clr_d;
    end
  end

  assign irq_code = {EXT_TYPE, irq_lvl};

endmodule

// File: rtl/sys_irq_router.sv
module sys_irq_router
  import sys_irq_router_pkg::*;
#(
  parameter logic [3:0] EXT_TYPE = 4'h1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic [LVL_W-1:0]  cpu_thresh_i,
  input  logic              cpu_ie_i,
  input  logic              reg_wr_i,
  input  logic [OFS_W-1:0]  reg_addr_i,
  input  logic [NSRC-1:0]   reg_wdata_i,
  output logic [NSRC-1:0]   reg_rdata_o,
  output logic              irq_req_o,
  output logic [LVL_W-1:0]  irq_lvl_o,
  output logic [CPU_W-1:0]  irq_cpu_o,
  output logic [7:0]        irq_code_o,
  output logic              lvl_vld_o,
  output logic [CPU_W-1:0]  lvl_cpu_o,
  output logic [NLVL-1:0]   lvl_set_o,
  output logic [NLVL-1:0]   lvl_clr_o
);

  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic [NSRC-1:0]  src_q;
  logic [NSRC-1:0]  pend_q, dis_q;
  logic [CPU_W-1:0] tgt_q;
  logic [NSRC-1:0]  pend_set, pend_clr;
  logic [NLVL-1:0]  lvl_set, lvl_clr;
  logic             any_chg, hit;
  logic [LVL_W-1:0] hit_lvl;

  // Reset asserts at once, releases on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) src_q <= '0;
    else             src_q <= src_i;
  end

  sirq_event_fold u_fold (
    .src_now  (src_i),
    .src_prev (src_q),
    .dis_cur  (dis_q),
    .thresh   (cpu_thresh_i),
    .ie       (cpu_ie_i),
    .pend_set (pend_set),
    .pend_clr (pend_clr),
    .lvl_set  (lvl_set),
    .lvl_clr  (lvl_clr),
    .any_chg  (any_chg),
    .hit      (hit),
    .hit_lvl  (hit_lvl)
  );

  sirq_state_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr       (reg_wr_i),
    .addr     (reg_addr_i),
    .wdata    (reg_wdata_i),
    .pend_set (pend_set),
    .pend_clr (pend_clr),
    .pend_q   (pend_q),
    .dis_q    (dis_q),
    .tgt_q    (tgt_q),
    .rdata    (reg_rdata_o)
  );

  sirq_req_reg #(.EXT_TYPE(EXT_TYPE)) u_req (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .hit      (hit),
    .hit_lvl  (hit_lvl),
    .tgt      (tgt_q),
    .any_chg  (any_chg),
    .lvl_set  (lvl_set),
    .lvl_clr  (lvl_clr),
    .irq_req  (irq_req_o),
    .irq_lvl  (irq_lvl_o),
    .irq_cpu  (irq_cpu_o),
    .irq_code (irq_code_o),
    .upd_vld  (lvl_vld_o),
    .upd_cpu  (lvl_cpu_o),
    .upd_set  (lvl_set_o),
    .upd_clr  (lvl_clr_o)
  );

endmodule

// File: rtl/sys_irq_router_chk.sv
module sys_irq_router_chk
  import sys_irq_router_pkg::*;
(
  input logic             clk,
  input logic             rst_sync_n,
  input logic             irq_req_o,
  input logic [LVL_W-1:0] irq_lvl_o,
  input logic [CPU_W-1:0] irq_cpu_o,
  input logic [LVL_W-1:0] cpu_thresh_i,
  input logic             cpu_ie_i,
  input logic [CPU_W-1:0] tgt_q,
  input logic [NSRC-1:0]  dis_q,
  input logic [NSRC-1:0]  pend_q,
  input logic             reg_wr_i,
  input logic [OFS_W-1:0] reg_addr_i,
  input logic [NSRC-1:0]  reg_wdata_i,
  input logic [NLVL-1:0]  lvl_set_o,
  input logic [NLVL-1:0]  lvl_clr_o
);

  logic [NSRC-1:0] dead;
  for (genvar g = 0; g < NSRC; g++) begin : g_dead
    assign dead[g] = (level_of(g) == '0);
  end

  assert_global_gate_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_req_o |-> !$past(dis_q[GLOBAL_BIT]));

  assert_thresh_gate_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_req_o && irq_lvl_o != TOP_LVL) |-> ($past(cpu_ie_i) && irq_lvl_o > $past(cpu_thresh_i)));

  assert_req_target_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_req_o |-> irq_cpu_o == $past(tgt_q));

  assert_req_level_nonzero_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_req_o |-> irq_lvl_o != '0);

  assert_mask_clears_pending_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(reg_wr_i) && $past(reg_addr_i) == 3'd3) |->
      ((pend_q & $past(reg_wdata_i) & ~FORCED) == '0));

  assert_forced_enabled_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(reg_wr_i) && $past(reg_addr_i) == 3'd2) |-> ((dis_q & FORCED) == '0));

  assert_dead_never_pending_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pend_q & dead) == '0);

  assert_set_clr_disjoint_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lvl_set_o & lvl_clr_o) == '0);

endmodule

bind sys_irq_router sys_irq_router_chk u_chk (.*);

// File: tb/sys_irq_router_test.sv
module sys_irq_router_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] FMASK = 32'h7FB2007F;

  logic        clk, rst_n;
  logic [31:0] src_i;
  logic [3:0]  cpu_thresh_i;
  logic        cpu_ie_i;
  logic        reg_wr_i;
  logic [2:0]  reg_addr_i;
  logic [31:0] reg_wdata_i;
  logic [31:0] reg_rdata_o;
  logic        irq_req_o;
  logic [3:0]  irq_lvl_o, irq_cpu_o;
  logic [7:0]  irq_code_o;
  logic        lvl_vld_o;
  logic [3:0]  lvl_cpu_o;
  logic [15:0] lvl_set_o, lvl_clr_o;

  sys_irq_router uut (.*);

  int nvec = 0;
  int nerr = 0;
  bit running = 0;

  logic [15:0] irq_q[$];
  string       irq_tag[$];
  logic [35:0] upd_q[$];
  string       upd_tag[$];

  logic [31:0] m_pend, m_dis, m_prev;
  logic [3:0]  m_tgt;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] lv(input int i);
    case (i)
      0: return 2;  1: return 3;  2: return 5;  3: return 7;  4: return 9;
      5: return 11; 7: return 14; 8: return 3;  9: return 5;  10: return 7;
      11: return 9; 12: return 11; 13: return 13; 14: return 12; 15: return 12;
      16: return 6; 18: return 4; 19: return 10; 20: return 8; 22: return 11;
      28: return 15;
      default: return 0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Monitor: drains the scoreboard as pulses appear.
  always @(negedge clk) begin
    if (running) begin
      if (irq_req_o) begin
        if (irq_q.size() == 0)
          check(0, "R8", "unexpected request", {irq_lvl_o, irq_cpu_o, irq_code_o}, 0);
        else begin
          logic [15:0] e;
          string t;
          e = irq_q.pop_front();
          t = irq_tag.pop_front();
          check({irq_lvl_o, irq_cpu_o, irq_code_o} == e, t,
                "request lvl/cpu/code (R11)", {irq_lvl_o, irq_cpu_o, irq_code_o}, e);
        end
      end
      if (lvl_vld_o) begin
        if (upd_q.size() == 0)
          check(0, "R7", "unexpected level update", {lvl_cpu_o, lvl_set_o, lvl_clr_o}, 0);
        else begin
          logic [35:0] e;
          string t;
          e = upd_q.pop_front();
          t = upd_tag.pop_front();
          check({lvl_cpu_o, lvl_set_o, lvl_clr_o} == e, t,
                "level update cpu/set/clr (R7)", {lvl_cpu_o, lvl_set_o, lvl_clr_o}, e);
        end
      end
    end
  end

  // Driver: applies a new source pattern and predicts its effects.
  task automatic drive_src(input logic [31:0] v, input string tag);
    logic [15:0] s, c;
    bit chg, hit;
    logic [3:0] hl, l;
    @(negedge clk);
    s = '0; c = '0; chg = 0; hit = 0; hl = '0;
    for (int i = 0; i < 32; i++) begin
      l = lv(i);
      if (l != 0) begin
        if (v[i] && !m_prev[i]) begin
          chg = 1; m_pend[i] = 1'b1; s[l] = 1'b1; c[l] = 1'b0;
          if (!m_dis[i] && !m_dis[31] &&
              (l == 4'd15 || (cpu_ie_i && l > cpu_thresh_i))) begin
            hit = 1; hl = l;
          end
        end else if (!v[i] && m_prev[i]) begin
          chg = 1; m_pend[i] = 1'b0; c[l] = 1'b1; s[l] = 1'b0;
        end
      end
    end
    if (hit) begin
      irq_q.push_back({hl, m_tgt, 4'h1, hl});
      irq_tag.push_back(tag);
    end
    if (chg) begin
      upd_q.push_back({m_tgt, s, c});
      upd_tag.push_back(tag);
    end
    src_i = v;
    m_prev = v;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    case (a)
      3'd2: m_dis = m_dis & ~(d | FMASK);
      3'd3: begin m_dis = m_dis | (d & ~FMASK); m_pend = m_pend & ~(d & ~FMASK); end
      3'd4: m_tgt = d[3:0];
      default: ;
    endcase
    @(posedge clk);
    #1 reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    reg_addr_i = a;
    #1 check(reg_rdata_o == e, tag, $sformatf("read offset %0d", a), reg_rdata_o, e);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    nvec++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; src_i = '0; cpu_thresh_i = '0; cpu_ie_i = 1'b0;
    reg_wr_i = 1'b0; reg_addr_i = '0; reg_wdata_i = '0;
    m_pend = '0; m_dis = '1; m_prev = '0; m_tgt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    running = 1;

    // R1: reset state
    rd(3'd0, 32'h0, "R1");
    rd(3'd1, 32'hFFFFFFFF, "R1");
    rd(3'd4, 32'h0, "R1");
    check(!irq_req_o && !lvl_vld_o, "R1", "no pulse after reset", {irq_req_o, lvl_vld_o}, 0);

    // R5: only the low nibble is kept
    wr(3'd4, 32'hABCD_0013);
    rd(3'd4, 32'h3, "R5");

    // R2: unused offsets
    rd(3'd2, 32'h0, "R2");
    rd(3'd3, 32'h0, "R2");
    rd(3'd5, 32'h0, "R2");
    rd(3'd6, 32'h0, "R2");
    rd(3'd7, 32'h0, "R2");

    // R3: forced positions enabled by a zero write
    wr(3'd2, 32'h0);
    rd(3'd1, 32'h804DFF80, "R3");
    wr(3'd2, 32'hFFFFFFFF);
    rd(3'd1, 32'h0, "R3");

    // R6 / R8: simple rise and fall
    cpu_ie_i = 1'b1; cpu_thresh_i = 4'd0;
    drive_src(32'h1, "R8");
    rd(3'd0, 32'h1, "R6");
    drive_src(32'h0, "R6");
    rd(3'd0, 32'h0, "R6");

    // R6: level-0 line is ignored
    drive_src(32'h40, "R6");
    rd(3'd0, 32'h0, "R6");
    drive_src(32'h0, "R6");

    // R8: threshold
    cpu_thresh_i = 4'd5;
    drive_src(32'h4, "R8");
    drive_src(32'hC, "R8");
    rd(3'd0, 32'hC, "R6");
    drive_src(32'h0, "R8");

    // R9: level 15 bypass with interrupts off; R12 pulse width
    cpu_ie_i = 1'b0;
    drive_src(32'h1000_0000, "R9");
    @(negedge clk);
    check(irq_req_o == 1'b1, "R9", "level-15 request present", irq_req_o, 1);
    @(negedge clk);
    check(irq_req_o == 1'b0, "R12", "request lasts one cycle", irq_req_o, 0);
    drive_src(32'h1000_0080, "R9");
    drive_src(32'h0, "R9");

    // R4: masking write clears pending, skips forced positions
    drive_src(32'h200, "R4");
    rd(3'd0, 32'h200, "R4");
    wr(3'd3, 32'hFFFFFFFF);
    rd(3'd1, 32'h804DFF80, "R4");
    rd(3'd0, 32'h0, "R4");

    // R8: global disable blocks an otherwise enabled line
    cpu_ie_i = 1'b1; cpu_thresh_i = 4'd0;
    drive_src(32'h201, "R8");
    rd(3'd0, 32'h1, "R8");
    wr(3'd2, 32'h8000_0000);
    rd(3'd1, 32'h004DFF80, "R3");

    // R10: lines 1 (L3), 4 (L9) and 19 (L10, disabled) rise together
    v = 32'h0008_0213;
    drive_src(v, "R10");

    // R7: lines 1 and 8 share level 3 and swap
    v = (v & ~32'h2) | 32'h100;
    drive_src(v, "R7");
    v = (v | 32'h2) & ~32'h100;
    drive_src(v, "R7");
    drive_src(32'h0, "R7");
    rd(3'd0, 32'h0, "R6");

    repeat (4) @(negedge clk);
    check(irq_q.size() == 0, "R8", "requests outstanding", irq_q.size(), 0);
    check(upd_q.size() == 0, "R7", "level updates outstanding", upd_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule